// File: doc/BRIEF.md
# Patrol Memory Scrub Sequencer

This block walks an attached word-organised memory once, from address 0 up to a programmable top address, and checks every word. Each word is read through a plain synchronous port with a fixed read latency and checked with a single-error-correct, double-error-detect code. When a word has one flipped bit, the block writes the repaired word back to the same address before it moves on. Each error found is reported on a one-cycle error interface, tagged with a code that marks it as a patrol finding, so a downstream log can tell it apart from errors raised by normal demand traffic.

Software drives the block through an 8-bit control register. Setting the enable bit while the block is idle starts one complete pass. At the end of the pass the block raises a sticky done flag, drops enable by itself and stops. Software starts the next pass by setting enable again. If enable is cleared in the middle of a pass, the walker stops cleanly after the word it is working on and does not set done. A detect-enable bit controls whether findings are reported and whether words are repaired.

Top module: `patrol_scrub`

## Requirements
- R1: After reset the control readback is 0x00 (enable bit 7, detect bit 5 and done bit 4 all clear), no memory access is issued, no error is reported, and the top-address register holds all ones.
- R2: A control write with bit 7 set while the block is idle starts a pass at address 0 and clears done in that same clock edge. A write with bit 7 set during a pass neither restarts nor disturbs that pass.
- R3: A pass reads every address from 0 to the top address captured at the start, inclusive, exactly once and in ascending order. It then sets done, clears bit 7 and issues no further accesses.
- R4: Done is sticky. It stays set until the next start, and the value written to bit 4 is ignored.
- R5: A control write with bit 7 clear during a pass stops the walker once the current word is finished. Done stays clear, bit 7 reads 0 and no further reads follow.
- R6: Read data is taken exactly RD_LAT cycles after the cycle in which the read request is asserted.
- R7: Codeword layout: bit positions 1..N (N = codeword width − 1) form a Hamming code. The positions that are powers of two hold check bits, and the other positions hold the data bits from LSB upward. Bit 0 is even overall parity. The syndrome is the XOR of the indices of the set bits in positions 1..N.
- R8: A word with odd overall parity and a syndrome no greater than N is correctable. Its bit at the syndrome index is flipped, and the repaired word is written to the same address in the cycle after the check, before the next read. It is reported with error-code bit 16.
- R9: A word with even parity and a syndrome from 1 to N is reported with code bit 6 (aliased uncorrectable). A word with a syndrome above N is reported with code bit 12 (non-aliased uncorrectable). In both cases the word is not written.
- R10: While detect (bit 5) is clear, no error is reported and no word is written back, but the walk still covers the full range.
- R11: Each report is a one-cycle err_valid pulse with exactly one code bit set and err_addr equal to the word address. A clean word gives no report.
- R12: A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 7 enable, bit 5 detect |
| ctrl_rdata | output | 8 | Control readback: bit 7 enable, bit 5 detect, bit 4 done |
| top_wr | input | 1 | Top-address register write strobe |
| top_wdata | input | ADDR_W | Highest address to visit in a pass |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request (repair) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | CW | Repaired codeword to write |
| mem_rdata | input | CW | Codeword returned RD_LAT cycles after the request |
| err_valid | output | 1 | One-cycle error report strobe |
| err_code | output | 17 | One-hot error code (bits 16, 12, 6) |
| err_addr | output | ADDR_W | Address of the reported word |

## Verification
A walker that holds a wrong address or misses its end condition shows up at the memory port within one word time, which is RD_LAT+2 cycles: as a repeated, skipped or out-of-range read, or as a done flag that never rises. A wrong latency count makes the walker capture a poisoned read bus, and on a memory with no errors this produces a bogus error report straight away. A misclassified syndrome shows up in the next cycle as a wrong code bit or a missing or extra write-back. A stop or start handshake that fails is visible in the read count after the control write, or in the done flag.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

   // control register field positions (software-visible)
   localparam int unsigned CTRL_EN_BIT   = 7;
   localparam int unsigned CTRL_DET_BIT  = 5;
   localparam int unsigned CTRL_DONE_BIT = 4;

   // error code space, one-hot, decoded by the error log
   localparam int unsigned ERR_W               = 17;
   localparam int unsigned ERR_PATROL_CE       = 16;
   localparam int unsigned ERR_PATROL_UE_ALIAS = 6;
   localparam int unsigned ERR_PATROL_UE_FAR   = 12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_CHECK,
      ST_WB
   } walk_state_t;

   // number of Hamming check bits for a data width
   function automatic int unsigned ecc_par_bits(input int unsigned dw);
      int unsigned p;
      p = 1;
      while ((1 << p) < (dw + p + 1)) p++;
      return p;
   endfunction

endpackage

// File: rtl/scrub_secded.sv
module scrub_secded #(
   parameter int unsigned CW    = 13,
   parameter int unsigned PAR_W = 4
) (
   input  logic [CW-1:0] word,
   output logic          single_fix,
   output logic          multi_alias,
   output logic          multi_far,
   output logic [CW-1:0] fixed
);

   localparam logic [PAR_W:0] LAST_POS = (PAR_W+1)'(CW - 1);

   logic [PAR_W-1:0] syn;
   logic             par_odd;
   logic             in_range;

   always_comb begin
      syn = '0;
      for (int i = 1; i < int'(CW); i++) begin
         if (word[i]) syn = syn ^ PAR_W'(i);
      end
   end

   assign par_odd  = ^word;
   assign in_range = ({1'b0, syn} <= LAST_POS);

   assign single_fix  = par_odd && in_range;
   assign multi_alias = !par_odd && (syn != '0) && in_range;
   assign multi_far   = !in_range;

   assign fixed = single_fix ? (word ^ (CW'(1) << syn)) : word;

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
   import scrub_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [7:0]        wdata,
   input  logic              top_wr,
   input  logic [ADDR_W-1:0] top_wdata,
   input  logic              busy,
   input  logic              pass_done,
   output logic              start,
   output logic              run,
   output logic              det_en,
   output logic [ADDR_W-1:0] top_addr,
   output logic [7:0]        rdata
);

   logic              en_q;
   logic              det_q;
   logic              done_q;
   logic [ADDR_W-1:0] top_q;
   logic              unused_wbits;

   assign unused_wbits = ^{wdata[6], wdata[4:0]};

   // a start only counts when the walker is idle
   assign start = wr && wdata[CTRL_EN_BIT] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         det_q  <= 1'b0;
         done_q <= 1'b0;
         top_q  <= '1;
      end else begin
         if (wr) begin
            en_q  <= wdata[CTRL_EN_BIT];
            det_q <= wdata[CTRL_DET_BIT];
         end
         if (pass_done) begin
            en_q   <= 1'b0;
            done_q <= 1'b1;
         end
         if (start) done_q <= 1'b0;
         if (top_wr) top_q <= top_wdata;
      end
   end

   assign run      = en_q;
   assign det_en   = det_q;
   assign top_addr = top_q;

   always_comb begin
      rdata                = '0;
      rdata[CTRL_EN_BIT]   = en_q;
      rdata[CTRL_DET_BIT]  = det_q;
      rdata[CTRL_DONE_BIT] = done_q;
   end

endmodule

// File: rtl/scrub_walker.sv
module scrub_walker
   import scrub_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CW     = 13,
   parameter int unsigned RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic              det_en,
   input  logic [ADDR_W-1:0] top_in,
   input  logic [CW-1:0]     mem_rdata,
   input  logic              single_fix,
   input  logic              multi_alias,
   input  logic              multi_far,
   input  logic [CW-1:0]     fixed,
   output logic [CW-1:0]     rd_word,
   output logic              busy,
   output logic              pass_done,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [CW-1:0]     mem_wdata,
   output logic              err_valid,
   output logic [ERR_W-1:0]  err_code,
   output logic [ADDR_W-1:0] err_addr
);

   walk_state_t       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] top_q;
   logic [CW-1:0]     rd_q;
   logic [CW-1:0]     fix_q;
   logic              err_valid_q;
   logic [ERR_W-1:0]  err_code_q;
   logic [ADDR_W-1:0] err_addr_q;

   logic              lat_hit;
   logic [ERR_W-1:0]  code_now;
   logic              report;
   logic              need_wb;
   logic              word_end;
   logic              last;

   // read latency counter: a single-cycle memory needs none
   if (RD_LAT == 1) begin : g_lat_one
      assign lat_hit = 1'b1;
   end else begin : g_lat_cnt
      localparam int unsigned LW = $clog2(RD_LAT + 1);
      logic [LW-1:0] lat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 lat_q <= LW'(1);
         else if (state_q != ST_WAIT) lat_q <= LW'(1);
         else                        lat_q <= lat_q + LW'(1);
      end
      assign lat_hit = (lat_q == LW'(RD_LAT));
   end

   always_comb begin
      code_now                      = '0;
      code_now[ERR_PATROL_CE]       = single_fix;
      code_now[ERR_PATROL_UE_ALIAS] = multi_alias;
      code_now[ERR_PATROL_UE_FAR]   = multi_far;
   end

   assign report    = (state_q == ST_CHECK) && det_en && (|code_now);
   assign need_wb   = (state_q == ST_CHECK) && det_en && single_fix;
   assign word_end  = ((state_q == ST_CHECK) && !need_wb) || (state_q == ST_WB);
   assign last      = (addr_q == top_q);
   assign pass_done = word_end && run && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         top_q       <= '0;
         rd_q        <= '0;
         fix_q       <= '0;
         err_valid_q <= 1'b0;
         err_code_q  <= '0;
         err_addr_q  <= '0;
      end else begin
         err_valid_q <= report;
         err_code_q  <= report ? code_now : '0;
         if (report) err_addr_q <= addr_q;

         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q  <= '0;
                  top_q   <= top_in;
                  state_q <= ST_READ;
               end
            end
            ST_READ:  state_q <= ST_WAIT;
            ST_WAIT: begin
               if (lat_hit) begin
                  rd_q    <= mem_rdata;
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               fix_q <= fixed;
               if (need_wb) state_q <= ST_WB;
            end
            ST_WB:    state_q <= ST_WB;
            default:  state_q <= ST_IDLE;
         endcase

         // word boundary: stop, finish or advance
         if (word_end) begin
            if (!run || last) begin
               state_q <= ST_IDLE;
            end else begin
               addr_q  <= addr_q + 1'b1;
               state_q <= ST_READ;
            end
         end
      end
   end

   assign rd_word   = rd_q;
   assign busy      = (state_q != ST_IDLE);
   assign mem_rd_en = (state_q == ST_READ);
   assign mem_wr_en = (state_q == ST_WB);
   assign mem_addr  = addr_q;
   assign mem_wdata = fix_q;
   assign err_valid = err_valid_q;
   assign err_code  = err_code_q;
   assign err_addr  = err_addr_q;

endmodule

// File: rtl/patrol_scrub.sv
module patrol_scrub #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned RD_LAT = 2
) (
   input  logic                                            clk,
   input  logic                                            rst_n,
   input  logic                                            ctrl_wr,
   input  logic [7:0]                                      ctrl_wdata,
   output logic [7:0]                                      ctrl_rdata,
   input  logic                                            top_wr,
   input  logic [ADDR_W-1:0]                               top_wdata,
   output logic                                            mem_rd_en,
   output logic                                            mem_wr_en,
   output logic [ADDR_W-1:0]                               mem_addr,
   output logic [DATA_W+scrub_pkg::ecc_par_bits(DATA_W):0] mem_wdata,
   input  logic [DATA_W+scrub_pkg::ecc_par_bits(DATA_W):0] mem_rdata,
   output logic                                            err_valid,
   output logic [scrub_pkg::ERR_W-1:0]                     err_code,
   output logic [ADDR_W-1:0]                               err_addr
);

   localparam int unsigned PAR_W = scrub_pkg::ecc_par_bits(DATA_W);
   localparam int unsigned CW    = DATA_W + PAR_W + 1;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("patrol_scrub: DATA_W must be at least 2");
   end
   if (RD_LAT < 1) begin : g_bad_rd_lat
      $error("patrol_scrub: RD_LAT must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("patrol_scrub: ADDR_W must be at least 1");
   end

   logic              start;
   logic              run;
   logic              det_en;
   logic              busy;
   logic              pass_done;
   logic [ADDR_W-1:0] top_addr;
   logic [CW-1:0]     rd_word;
   logic [CW-1:0]     fixed;
   logic              single_fix;
   logic              multi_alias;
   logic              multi_far;

   scrub_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctrl_wr),
      .wdata     (ctrl_wdata),
      .top_wr    (top_wr),
      .top_wdata (top_wdata),
      .busy      (busy),
      .pass_done (pass_done),
      .start     (start),
      .run       (run),
      .det_en    (det_en),
      .top_addr  (top_addr),
      .rdata     (ctrl_rdata)
   );

   scrub_secded #(.CW(CW), .PAR_W(PAR_W)) u_ecc (
      .word        (rd_word),
      .single_fix  (single_fix),
      .multi_alias (multi_alias),
      .multi_far   (multi_far),
      .fixed       (fixed)
   );

   scrub_walker #(.ADDR_W(ADDR_W), .CW(CW), .RD_LAT(RD_LAT)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .run         (run),
      .det_en      (det_en),
      .top_in      (top_addr),
      .mem_rdata   (mem_rdata),
      .single_fix  (single_fix),
      .multi_alias (multi_alias),
      .multi_far   (multi_far),
      .fixed       (fixed),
      .rd_word     (rd_word),
      .busy        (busy),
      .pass_done   (pass_done),
      .mem_rd_en   (mem_rd_en),
      .mem_wr_en   (mem_wr_en),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .err_valid   (err_valid),
      .err_code    (err_code),
      .err_addr    (err_addr)
   );

endmodule

// File: rtl/patrol_scrub_chk.sv
module patrol_scrub_chk #(
   parameter int unsigned ADDR_W = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        start_req,
   input logic                        done_flag,
   input logic                        det_flag,
   input logic                        mem_rd_en,
   input logic                        mem_wr_en,
   input logic [ADDR_W-1:0]           mem_addr,
   input logic                        err_valid,
   input logic [scrub_pkg::ERR_W-1:0] err_code
);

   p_port_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   p_code_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> ($countones(err_code) == 1));

   p_report_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |=> !err_valid);

   p_wb_reported_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (err_valid && err_code[scrub_pkg::ERR_PATROL_CE]));

   p_wb_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $stable(mem_addr));

   p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !start_req) |=> done_flag);

   p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag |-> (!mem_rd_en && !mem_wr_en));

   p_done_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_flag) |-> $past(start_req));

   p_report_needs_det_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> $past(det_flag));

endmodule

bind patrol_scrub patrol_scrub_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_req (ctrl_wr && ctrl_wdata[7]),
   .done_flag (ctrl_rdata[4]),
   .det_flag  (ctrl_rdata[5]),
   .mem_rd_en (mem_rd_en),
   .mem_wr_en (mem_wr_en),
   .mem_addr  (mem_addr),
   .err_valid (err_valid),
   .err_code  (err_code)
);

// File: tb/tb_patrol_scrub.sv
module tb_patrol_scrub;

   localparam int DATA_W = 8;
   localparam int ADDR_W = 6;
   localparam int RD_LAT = 2;
   localparam int CW     = 13;
   localparam int NPOS   = CW - 1;
   localparam int MEM_D  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ctrl_wr = 1'b0;
   logic [7:0]        ctrl_wdata = '0;
   logic [7:0]        ctrl_rdata;
   logic              top_wr = 1'b0;
   logic [ADDR_W-1:0] top_wdata = '0;
   logic              mem_rd_en, mem_wr_en;
   logic [ADDR_W-1:0] mem_addr;
   logic [CW-1:0]     mem_wdata;
   logic [CW-1:0]     mem_rdata;
   logic              err_valid;
   logic [16:0]       err_code;
   logic [ADDR_W-1:0] err_addr;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   patrol_scrub #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) dut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .top_wr(top_wr), .top_wdata(top_wdata),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .err_valid(err_valid),
      .err_code(err_code), .err_addr(err_addr)
   );

   // memory model: data visible RD_LAT cycles after the request cycle,
   // poisoned with all ones when no read was requested
   logic [CW-1:0] mem    [MEM_D];
   logic [CW-1:0] golden [MEM_D];
   logic [CW-1:0] pipe   [RD_LAT];

   always @(posedge clk) begin
      if (mem_wr_en) mem[mem_addr] <= mem_wdata;
      pipe[0] <= mem_rd_en ? mem[mem_addr] : '1;
      for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
   end
   assign mem_rdata = pipe[RD_LAT-1];

   // port monitor
   int visits [MEM_D];
   int wr_at  [MEM_D];
   int err_at [MEM_D];
   int rd_total, wr_total, err_total, order_bad, wb_bad, excl_bad, onehot_bad;
   int exp_next, last_rd;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en && mem_wr_en) excl_bad++;
         if (mem_rd_en) begin
            visits[mem_addr]++;
            rd_total++;
            if (int'(mem_addr) != exp_next) order_bad++;
            exp_next = int'(mem_addr) + 1;
            last_rd  = int'(mem_addr);
         end
         if (mem_wr_en) begin
            wr_total++;
            wr_at[mem_addr]++;
            if (int'(mem_addr) != last_rd) wb_bad++;
         end
         if (err_valid) begin
            err_total++;
            if ($countones(err_code) != 1) onehot_bad++;
            for (int b = 0; b < 17; b++) if (err_code[b]) err_at[err_addr] = b;
         end
      end
   end

   task automatic clear_stats();
      for (int a = 0; a < MEM_D; a++) begin
         visits[a] = 0; wr_at[a] = 0; err_at[a] = -1;
      end
      rd_total = 0; wr_total = 0; err_total = 0; order_bad = 0;
      wb_bad = 0; excl_bad = 0; onehot_bad = 0; exp_next = 0; last_rd = -1;
   endtask

   // codeword rules as stated in R7
   function automatic logic [CW-1:0] enc(input logic [DATA_W-1:0] d);
      logic [CW-1:0] w;
      int k;
      logic p;
      w = '0;
      k = 0;
      for (int pos = 1; pos < CW; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            w[pos] = d[k];
            k++;
         end
      end
      for (int b = 0; (1 << b) < CW; b++) begin
         p = 1'b0;
         for (int pos = 1; pos < CW; pos++)
            if (((pos >> b) & 1) == 1 && pos != (1 << b)) p = p ^ w[pos];
         w[1 << b] = p;
      end
      w[0] = ^w[CW-1:1];
      return w;
   endfunction

   // expected code bit per R8/R9, -1 for a clean word
   function automatic int exp_bit(input logic [CW-1:0] w);
      int s;
      s = 0;
      for (int pos = 1; pos < CW; pos++) if (w[pos]) s = s ^ pos;
      if (s > NPOS) return 12;
      if (^w) return 16;
      if (s != 0) return 6;
      return -1;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic load(input int seed);
      for (int a = 0; a < MEM_D; a++) begin
         mem[a]    = enc(DATA_W'(a * 37 + seed));
         golden[a] = mem[a];
      end
   endtask

   task automatic ctrl_write(input logic [7:0] v);
      @(negedge clk);
      ctrl_wr = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic top_write(input int t);
      @(negedge clk);
      top_wr = 1'b1;
      top_wdata = ADDR_W'(t);
      @(negedge clk);
      top_wr = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (ctrl_rdata[4]) begin
            ok = 1'b1;
            break;
         end
      end
      repeat (2) @(negedge clk);
   endtask

   function automatic int visits_ok(input int top);
      int bad;
      bad = 0;
      for (int a = 0; a < MEM_D; a++)
         if (visits[a] != ((a <= top) ? 1 : 0)) bad++;
      return bad;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk(ctrl_rdata == 8'h00, "R1 control readback after reset", ctrl_rdata, 0);
      chk(!mem_rd_en && !mem_wr_en && !err_valid, "R1 quiet ports after reset",
          {mem_rd_en, mem_wr_en, err_valid}, 0);
   endtask

   task automatic t_full_pass();
      bit ok;
      int diff;
      load(5);
      clear_stats();
      ctrl_write(8'hA0);
      chk(ctrl_rdata[7] && !ctrl_rdata[4], "R2 enable set, done clear at start",
          ctrl_rdata, 8'hA0);
      wait_done(ok);
      chk(ok, "R3 done after full default-range pass", ok, 1);
      chk(visits_ok(MEM_D - 1) == 0, "R1 R3 every address once up to reset top",
          visits_ok(MEM_D - 1), 0);
      chk(order_bad == 0, "R3 ascending order", order_bad, 0);
      chk(ctrl_rdata[7] == 1'b0, "R3 enable drops at end", ctrl_rdata[7], 0);
      chk(err_total == 0, "R6 R11 clean memory gives no report", err_total, 0);
      chk(wr_total == 0, "R11 clean memory gives no write", wr_total, 0);
      diff = 0;
      for (int a = 0; a < MEM_D; a++) if (mem[a] != golden[a]) diff++;
      chk(diff == 0, "R3 memory untouched", diff, 0);
      repeat (10) @(negedge clk);
      chk(rd_total == MEM_D, "R3 no accesses after done", rd_total, MEM_D);
   endtask

   task automatic t_top_limit();
      bit ok;
      top_write(10);
      ctrl_write(8'h30);
      repeat (3) @(negedge clk);
      chk(ctrl_rdata[4] == 1'b1, "R4 done survives idle write of bit 4 and bit 7 clear",
          ctrl_rdata[4], 1);
      ctrl_write(8'h20);
      chk(ctrl_rdata[4] == 1'b1, "R4 write with bit 4 clear leaves done set",
          ctrl_rdata[4], 1);
      clear_stats();
      ctrl_write(8'hA0);
      chk(ctrl_rdata[4] == 1'b0, "R2 done cleared when pass starts", ctrl_rdata[4], 0);
      wait_done(ok);
      chk(ok && visits_ok(10) == 0, "R3 pass stops at programmed top 10",
          visits_ok(10), 0);
   endtask

   task automatic t_single();
      bit ok;
      int bad;
      load(91);
      mem[3] = mem[3] ^ (CW'(1) << 5);
      mem[7] = mem[7] ^ CW'(1);
      mem[9] = mem[9] ^ (CW'(1) << 8);
      top_write(15);
      clear_stats();
      ctrl_write(8'hA0);
      wait_done(ok);
      bad = 0;
      for (int a = 0; a < MEM_D; a++) if (mem[a] != golden[a]) bad++;
      chk(ok && bad == 0, "R7 R8 single-bit words repaired in memory", bad, 0);
      chk(wr_total == 3 && wr_at[3] == 1 && wr_at[7] == 1 && wr_at[9] == 1,
          "R8 one write-back per corrected word", wr_total, 3);
      chk(wb_bad == 0, "R8 write-back to the address just read, before next read",
          wb_bad, 0);
      chk(err_total == 3 && err_at[3] == 16 && err_at[7] == 16 && err_at[9] == 16,
          "R8 R11 correctable code bit 16 at word address", err_at[3], 16);
      chk(onehot_bad == 0, "R11 one code bit per report", onehot_bad, 0);
      chk(visits_ok(15) == 0, "R8 each word still visited once", visits_ok(15), 0);
   endtask

   task automatic t_double();
      bit ok;
      logic [CW-1:0] w2, w5, w6;
      load(200);
      mem[2] = mem[2] ^ (CW'(1) << 1) ^ (CW'(1) << 2);
      mem[5] = mem[5] ^ (CW'(1) << 5) ^ (CW'(1) << 8);
      mem[6] = mem[6] ^ (CW'(1) << 1) ^ (CW'(1) << 2) ^ (CW'(1) << 12);
      w2 = mem[2]; w5 = mem[5]; w6 = mem[6];
      clear_stats();
      ctrl_write(8'hA0);
      wait_done(ok);
      chk(ok && err_at[2] == exp_bit(w2) && exp_bit(w2) == 6,
          "R9 aliased double error code bit 6", err_at[2], 6);
      chk(err_at[5] == exp_bit(w5) && exp_bit(w5) == 12,
          "R9 non-aliased double error code bit 12", err_at[5], 12);
      chk(err_at[6] == exp_bit(w6) && exp_bit(w6) == 12,
          "R9 odd-parity out-of-range syndrome code bit 12", err_at[6], 12);
      chk(err_total == 3, "R11 one report per bad word", err_total, 3);
      chk(wr_total == 0 && mem[2] == w2 && mem[5] == w5 && mem[6] == w6,
          "R9 uncorrectable words left unchanged", wr_total, 0);
   endtask

   task automatic t_detect_off();
      bit ok;
      logic [CW-1:0] w4;
      load(17);
      mem[4] = mem[4] ^ (CW'(1) << 6);
      w4 = mem[4];
      clear_stats();
      ctrl_write(8'h80);
      wait_done(ok);
      chk(ok && err_total == 0, "R10 no report with detect clear", err_total, 0);
      chk(wr_total == 0 && mem[4] == w4, "R10 no repair with detect clear", wr_total, 0);
      chk(visits_ok(15) == 0, "R10 full walk with detect clear", visits_ok(15), 0);
   endtask

   task automatic t_stop_restart();
      bit ok;
      int snap, k, bad;
      load(3);
      top_write(MEM_D - 1);
      clear_stats();
      ctrl_write(8'hA0);
      repeat (40) @(negedge clk);
      ctrl_write(8'h20);
      repeat (10) @(negedge clk);
      snap = rd_total;
      repeat (30) @(negedge clk);
      chk(rd_total == snap, "R5 no reads after stop boundary", rd_total, snap);
      chk(ctrl_rdata[4] == 1'b0 && ctrl_rdata[7] == 1'b0, "R5 stopped without done",
          ctrl_rdata, 8'h20);
      k = 0;
      while (k < MEM_D && visits[k] == 1) k++;
      bad = 0;
      for (int a = k; a < MEM_D; a++) if (visits[a] != 0) bad++;
      chk(k > 0 && k < MEM_D && bad == 0, "R5 visited set is a clean prefix", k, snap);
      clear_stats();
      ctrl_write(8'hA0);
      repeat (30) @(negedge clk);
      ctrl_write(8'hA0);
      wait_done(ok);
      chk(ok && visits_ok(MEM_D - 1) == 0 && order_bad == 0,
          "R2 restart runs from 0, busy write ignored", visits_ok(MEM_D - 1), 0);
      chk(excl_bad == 0, "R12 read and write never together", excl_bad, 0);
   endtask

   initial begin
      clear_stats();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_pass();
      t_top_limit();
      t_single();
      t_double();
      t_detect_off();
      t_stop_restart();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule